// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block decides when a small 8-bit processor stops its normal instruction stream to service an interrupt. Each maskable source and the single non-maskable source sets a pending latch. The latch stays set until that interrupt is taken or until an explicit clear command drops it. When the core reports that an instruction has finished, the block picks the winning source. The winner is the non-maskable source if it is pending. Otherwise it is the lowest-numbered maskable source that is pending, individually enabled and allowed by the master enable flag. The block then runs a fixed eight-cycle entry sequence on a byte-wide memory bus.

The entry sequence does four things in order. It saves the return address and the status byte on a stack that grows downward. It reads a two-byte entry address from the winner's slot in the vector table. It hands that address to the core as the new program counter. While it does this it holds the core stalled through a busy output. A return command runs the reverse: the status byte and the return address are popped, the stack pointer moves back up by three, and the master enable flag takes its value from the popped status byte. The accumulator and the general registers are left to software.

Top module: `irq_entry_seq`

## Requirements
- R1: A request pulse sets its pending latch. The latch holds until that source is accepted or until a clear command removes it; a clear command removes only the sources whose mask bit is 1.
- R2: Acceptance starts only on a cycle where the core reports a completed instruction (instr_done high); busy rises on the following cycle.
- R3: An entry keeps busy high for exactly 8 cycles, and pc_load pulses in the 8th of them. After reset busy, pc_load, mem_we and mem_re are 0.
- R4: Acceptance clears the master enable flag (irq_en) and the accepted source's latch, so the same request is not taken twice.
- R5: A maskable request is taken only while irq_en is 1 and its src_en bit is 1. irq_en is 0 after reset; ei_cmd sets it and di_cmd clears it while the block is idle.
- R6: Priority order: the non-maskable source first, then maskable sources from index 0 upward (the lowest index wins).
- R7: The entry writes the return PC high byte to stack address SP, the low byte to SP-1 and the status byte to SP-2, in that order. The stack address is {8'h01, SP}. SP then ends 3 lower. SP is 8'hFF after reset.
- R8: Maskable source i uses the vector slot VEC_BASE+2*i and the non-maskable source uses VEC_BASE+2*NUM_SRC. The low byte is read at the slot address and then the high byte at the next address, and pc_out becomes {high, low}.
- R9: The non-maskable source is taken whatever irq_en says. Once it is taken, no interrupt of any kind is accepted until a return completes.
- R10: A return reads the status byte at SP+1, the PC low byte at SP+2 and the high byte at SP+3. It keeps busy high for 4 cycles, pulses pc_load and psw_load in the 4th with the popped values, raises SP by 3, and restores irq_en from bit 2 of the popped status byte.
- R11: The saved status byte is psw_in with bit 2 replaced by the value irq_en had at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NUM_SRC | Request pulses from the maskable sources |
| src_en | input | NUM_SRC | Per-source enable flags |
| nmi_req | input | 1 | Non-maskable request pulse |
| clr_cmd | input | 1 | Clear command for pending latches |
| clr_mask | input | NUM_SRC | Latches affected by clr_cmd |
| ei_cmd | input | 1 | Set master enable (when idle) |
| di_cmd | input | 1 | Clear master enable (when idle) |
| instr_done | input | 1 | Core has completed the current instruction |
| reti_cmd | input | 1 | Return-from-interrupt command |
| pc_in | input | ADDR_W | Return address offered by the core |
| psw_in | input | 8 | Status byte offered by the core |
| busy | output | 1 | Stalls the core's instruction fetch |
| irq_en | output | 1 | Master enable flag |
| sp_out | output | SP_W | Stack pointer |
| mem_addr | output | ADDR_W | Memory bus address |
| mem_wdata | output | 8 | Memory bus write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid in the strobe cycle |
| pc_load | output | 1 | Load pc_out into the program counter |
| pc_out | output | ADDR_W | New program counter |
| psw_load | output | 1 | Load psw_out into the status register |
| psw_out | output | 8 | Restored status byte |

## Verification
The bench sweeps every non-empty pending pattern against every enable pattern across four sources. A broken priority encoder would take a higher index or a masked source, and its wrong vector slot would show up directly in pc_out. The bench also checks that a cleared latch, an already-serviced latch and a request made while the master flag is 0 are all refused. A latch that fails to clear, or a missing master-enable gate, would start a busy window where none is expected. Nested service and non-maskable lockout are covered by checking SP, irq_en and the exact stack addresses across two entries and two returns. A sequencer that swapped the push order, lost the enable bit in the saved status byte, or accepted a request during non-maskable service would fail there.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_ENTRY  = 2'd1,
      SQ_RETURN = 2'd2
   } sq_state_t;

   localparam int ENTRY_CYCLES  = 8;
   localparam int RETURN_CYCLES = 4;
   localparam int STEP_W        = 3;

   // entry step numbers
   localparam logic [STEP_W-1:0] EN_PUSH_HI = 3'd2;
   localparam logic [STEP_W-1:0] EN_PUSH_LO = 3'd3;
   localparam logic [STEP_W-1:0] EN_PUSH_ST = 3'd4;
   localparam logic [STEP_W-1:0] EN_VEC_LO  = 3'd5;
   localparam logic [STEP_W-1:0] EN_VEC_HI  = 3'd6;

   // return step numbers
   localparam logic [STEP_W-1:0] RT_POP_ST = 3'd0;
   localparam logic [STEP_W-1:0] RT_POP_LO = 3'd1;
   localparam logic [STEP_W-1:0] RT_POP_HI = 3'd2;

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req_i,
   input  logic               nmi_req_i,
   input  logic               clr_cmd_i,
   input  logic [NUM_SRC-1:0] clr_mask_i,
   input  logic [NUM_SRC-1:0] ack_src_i,
   input  logic               ack_nmi_i,
   output logic [NUM_SRC-1:0] pend_o,
   output logic               nmi_pend_o
);

   logic [NUM_SRC-1:0] drop;
   assign drop = ack_src_i | (clr_mask_i & {NUM_SRC{clr_cmd_i}});

   for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
      always_ff @(posedge clk) begin
         if (!rst_n)             pend_o[gi] <= 1'b0;
         else if (src_req_i[gi]) pend_o[gi] <= 1'b1;
         else if (drop[gi])      pend_o[gi] <= 1'b0;
      end

      // R1: a pending latch survives any cycle without ack or clear
      p_latch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_o[gi] && !ack_src_i[gi] && !(clr_cmd_i && clr_mask_i[gi])) |=> pend_o[gi]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         nmi_pend_o <= 1'b0;
      else if (nmi_req_i) nmi_pend_o <= 1'b1;
      else if (ack_nmi_i) nmi_pend_o <= 1'b0;
   end

   // R4: an acknowledge only ever targets a latch that is pending
   p_ack_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((ack_src_i & ~pend_o) == '0) && (!ack_nmi_i || nmi_pend_o));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int              NUM_SRC  = 4,
   parameter int              ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFE0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic [NUM_SRC-1:0] src_en_i,
   input  logic               nmi_pend_i,
   input  logic               ie_i,
   input  logic               lock_i,
   output logic               win_valid_o,
   output logic               win_nmi_o,
   output logic [NUM_SRC-1:0] win_onehot_o,
   output logic [ADDR_W-1:0]  win_vec_o
);

   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam logic [ADDR_W-1:0] NMI_VEC = VEC_BASE + ADDR_W'(2 * NUM_SRC);

   logic [NUM_SRC-1:0] elig;
   logic [IDX_W-1:0]   idx;
   logic               any;

   assign elig = pend_i & src_en_i & {NUM_SRC{ie_i}};

   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (elig[i]) begin
            idx = IDX_W'(i);
            any = 1'b1;
         end
      end
   end

   always_comb begin
      win_valid_o  = 1'b0;
      win_nmi_o    = 1'b0;
      win_onehot_o = '0;
      win_vec_o    = VEC_BASE;
      if (!lock_i) begin
         if (nmi_pend_i) begin
            win_valid_o = 1'b1;
            win_nmi_o   = 1'b1;
            win_vec_o   = NMI_VEC;
         end else if (any) begin
            win_valid_o       = 1'b1;
            win_onehot_o[idx] = 1'b1;
            win_vec_o         = VEC_BASE + {{(ADDR_W-IDX_W-1){1'b0}}, idx, 1'b0};
         end
      end
   end

   // R6: at most one maskable winner, and none with a lower eligible index
   p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win_onehot_o));
   p_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid_o && !win_nmi_o) |-> ((pend_i & src_en_i & (win_onehot_o - 1'b1)) == '0));
   // R5: a maskable winner requires the master flag
   p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid_o && !win_nmi_o) |-> ie_i);

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
   import irq_seq_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int SP_W       = 8,
   parameter int STACK_PAGE = 1,
   parameter int IE_BIT     = 2,
   parameter logic [SP_W-1:0] SP_INIT = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_done_i,
   input  logic              reti_cmd_i,
   input  logic              ei_cmd_i,
   input  logic              di_cmd_i,
   input  logic              win_valid_i,
   input  logic              win_nmi_i,
   input  logic [ADDR_W-1:0] win_vec_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [7:0]        psw_i,
   input  logic [7:0]        mem_rdata_i,
   output logic              accept_o,
   output logic              lock_o,
   output logic              ie_o,
   output logic              busy_o,
   output logic [SP_W-1:0]   sp_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [7:0]        mem_wdata_o,
   output logic              mem_we_o,
   output logic              mem_re_o,
   output logic              pc_load_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic              psw_load_o,
   output logic [7:0]        psw_o
);

   localparam int PAGE_W = ADDR_W - SP_W;
   localparam logic [PAGE_W-1:0] PAGE = PAGE_W'(STACK_PAGE);
   localparam logic [STEP_W-1:0] EN_LAST = STEP_W'(ENTRY_CYCLES - 1);
   localparam logic [STEP_W-1:0] RT_LAST = STEP_W'(RETURN_CYCLES - 1);

   sq_state_t         state_q;
   logic [STEP_W-1:0] step_q;
   logic [ADDR_W-1:0] ret_pc_q, vec_q;
   logic [7:0]        ret_psw_q, byte_a_q, byte_b_q, psw_q;
   logic [SP_W-1:0]   sp_q;
   logic              ie_q, lock_q;
   logic              ret_start, entry_last, ret_last;
   logic [7:0]        psw_mix;

   assign accept_o   = (state_q == SQ_IDLE) && instr_done_i && !reti_cmd_i && win_valid_i;
   assign ret_start  = (state_q == SQ_IDLE) && reti_cmd_i;
   assign entry_last = (state_q == SQ_ENTRY)  && (step_q == EN_LAST);
   assign ret_last   = (state_q == SQ_RETURN) && (step_q == RT_LAST);

   always_comb begin
      psw_mix         = psw_i;
      psw_mix[IE_BIT] = ie_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SQ_IDLE;
         step_q    <= '0;
         ret_pc_q  <= '0;
         ret_psw_q <= '0;
         vec_q     <= '0;
         byte_a_q  <= '0;
         byte_b_q  <= '0;
         psw_q     <= '0;
         sp_q      <= SP_INIT;
         ie_q      <= 1'b0;
         lock_q    <= 1'b0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               step_q <= '0;
               if (ret_start) begin
                  state_q <= SQ_RETURN;
               end else if (accept_o) begin
                  state_q   <= SQ_ENTRY;
                  ret_pc_q  <= pc_i;
                  ret_psw_q <= psw_mix;
                  vec_q     <= win_vec_i;
                  ie_q      <= 1'b0;
                  if (win_nmi_i) lock_q <= 1'b1;
               end else if (ei_cmd_i) begin
                  ie_q <= 1'b1;
               end else if (di_cmd_i) begin
                  ie_q <= 1'b0;
               end
            end
            SQ_ENTRY: begin
               step_q <= step_q + 1'b1;
               if (step_q == EN_PUSH_ST) sp_q     <= sp_q - SP_W'(3);
               if (step_q == EN_VEC_LO)  byte_a_q <= mem_rdata_i;
               if (step_q == EN_VEC_HI)  byte_b_q <= mem_rdata_i;
               if (entry_last) begin
                  state_q <= SQ_IDLE;
                  step_q  <= '0;
               end
            end
            SQ_RETURN: begin
               step_q <= step_q + 1'b1;
               if (step_q == RT_POP_ST) psw_q    <= mem_rdata_i;
               if (step_q == RT_POP_LO) byte_a_q <= mem_rdata_i;
               if (step_q == RT_POP_HI) byte_b_q <= mem_rdata_i;
               if (ret_last) begin
                  sp_q    <= sp_q + SP_W'(3);
                  ie_q    <= psw_q[IE_BIT];
                  lock_q  <= 1'b0;
                  state_q <= SQ_IDLE;
                  step_q  <= '0;
               end
            end
            default: begin
               state_q <= SQ_IDLE;
               step_q  <= '0;
            end
         endcase
      end
   end

   always_comb begin
      mem_addr_o  = {PAGE, sp_q};
      mem_wdata_o = '0;
      mem_we_o    = 1'b0;
      mem_re_o    = 1'b0;
      if (state_q == SQ_ENTRY) begin
         case (step_q)
            EN_PUSH_HI: begin
               mem_we_o    = 1'b1;
               mem_wdata_o = ret_pc_q[ADDR_W-1 -: 8];
            end
            EN_PUSH_LO: begin
               mem_we_o    = 1'b1;
               mem_addr_o  = {PAGE, sp_q - SP_W'(1)};
               mem_wdata_o = ret_pc_q[7:0];
            end
            EN_PUSH_ST: begin
               mem_we_o    = 1'b1;
               mem_addr_o  = {PAGE, sp_q - SP_W'(2)};
               mem_wdata_o = ret_psw_q;
            end
            EN_VEC_LO: begin
               mem_re_o   = 1'b1;
               mem_addr_o = vec_q;
            end
            EN_VEC_HI: begin
               mem_re_o   = 1'b1;
               mem_addr_o = vec_q + 1'b1;
            end
            default: ;
         endcase
      end else if (state_q == SQ_RETURN && step_q != RT_LAST) begin
         mem_re_o   = 1'b1;
         mem_addr_o = {PAGE, sp_q + SP_W'(step_q) + SP_W'(1)};
      end
   end

   assign busy_o     = (state_q != SQ_IDLE);
   assign lock_o     = lock_q;
   assign ie_o       = ie_q;
   assign sp_o       = sp_q;
   assign pc_load_o  = entry_last || ret_last;
   assign pc_o       = {byte_b_q, byte_a_q};
   assign psw_load_o = ret_last;
   assign psw_o      = psw_q;

   // R2: busy only rises after a completed instruction or a return command
   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(instr_done_i || reti_cmd_i));
   // R3: the entry load lands exactly eight busy cycles after an idle cycle
   p_entry_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load_o && !psw_load_o) |-> ($past(busy_o, 7) && !$past(busy_o, 8)));
   // R4: the master flag is down for the whole entry
   p_ie_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_ENTRY) |-> !ie_q);
   // R7: consecutive pushes walk downward one byte at a time
   p_push_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - 1'b1));
   p_bus_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we_o && mem_re_o));
   p_sp_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_q != $past(sp_q)) |-> ((sp_q == $past(sp_q) - SP_W'(3)) || (sp_q == $past(sp_q) + SP_W'(3))));
   // R9: while locked by a non-maskable entry, no new entry starts
   p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && state_q == SQ_IDLE) |=> (state_q != SQ_ENTRY));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
   parameter int                NUM_SRC    = 4,
   parameter int                ADDR_W     = 16,
   parameter int                SP_W       = 8,
   parameter int                STACK_PAGE = 1,
   parameter int                IE_BIT     = 2,
   parameter logic [SP_W-1:0]   SP_INIT    = 8'hFF,
   parameter logic [ADDR_W-1:0] VEC_BASE   = 16'hFFE0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic               nmi_req,
   input  logic               clr_cmd,
   input  logic [NUM_SRC-1:0] clr_mask,
   input  logic               ei_cmd,
   input  logic               di_cmd,
   input  logic               instr_done,
   input  logic               reti_cmd,
   input  logic [ADDR_W-1:0]  pc_in,
   input  logic [7:0]         psw_in,
   output logic               busy,
   output logic               irq_en,
   output logic [SP_W-1:0]    sp_out,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [7:0]         mem_wdata,
   output logic               mem_we,
   output logic               mem_re,
   input  logic [7:0]         mem_rdata,
   output logic               pc_load,
   output logic [ADDR_W-1:0]  pc_out,
   output logic               psw_load,
   output logic [7:0]         psw_out
);

   initial begin
      assert (NUM_SRC >= 1 && NUM_SRC <= 32) else $error("NUM_SRC out of range");
      assert (ADDR_W == 16) else $error("return address is two bytes: ADDR_W must be 16");
      assert (SP_W >= 2 && SP_W < ADDR_W) else $error("SP_W must leave a page field");
      assert (IE_BIT >= 0 && IE_BIT < 8) else $error("IE_BIT must index the status byte");
      assert (VEC_BASE[0] == 1'b0) else $error("VEC_BASE must be even");
   end

   logic [NUM_SRC-1:0] pend, win_onehot, ack_src;
   logic               nmi_pend, win_valid, win_nmi, accept, lock, ack_nmi;
   logic [ADDR_W-1:0]  win_vec;

   assign ack_src = win_onehot & {NUM_SRC{accept && !win_nmi}};
   assign ack_nmi = accept && win_nmi;

   irq_req_latch #(.NUM_SRC(NUM_SRC)) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_req_i  (src_req),
      .nmi_req_i  (nmi_req),
      .clr_cmd_i  (clr_cmd),
      .clr_mask_i (clr_mask),
      .ack_src_i  (ack_src),
      .ack_nmi_i  (ack_nmi),
      .pend_o     (pend),
      .nmi_pend_o (nmi_pend)
   );

   irq_prio_pick #(
      .NUM_SRC  (NUM_SRC),
      .ADDR_W   (ADDR_W),
      .VEC_BASE (VEC_BASE)
   ) u_pick (
      .clk          (clk),
      .rst_n        (rst_n),
      .pend_i       (pend),
      .src_en_i     (src_en),
      .nmi_pend_i   (nmi_pend),
      .ie_i         (irq_en),
      .lock_i       (lock),
      .win_valid_o  (win_valid),
      .win_nmi_o    (win_nmi),
      .win_onehot_o (win_onehot),
      .win_vec_o    (win_vec)
   );

   irq_seq_fsm #(
      .ADDR_W     (ADDR_W),
      .SP_W       (SP_W),
      .STACK_PAGE (STACK_PAGE),
      .IE_BIT     (IE_BIT),
      .SP_INIT    (SP_INIT)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .instr_done_i (instr_done),
      .reti_cmd_i   (reti_cmd),
      .ei_cmd_i     (ei_cmd),
      .di_cmd_i     (di_cmd),
      .win_valid_i  (win_valid),
      .win_nmi_i    (win_nmi),
      .win_vec_i    (win_vec),
      .pc_i         (pc_in),
      .psw_i        (psw_in),
      .mem_rdata_i  (mem_rdata),
      .accept_o     (accept),
      .lock_o       (lock),
      .ie_o         (irq_en),
      .busy_o       (busy),
      .sp_o         (sp_out),
      .mem_addr_o   (mem_addr),
      .mem_wdata_o  (mem_wdata),
      .mem_we_o     (mem_we),
      .mem_re_o     (mem_re),
      .pc_load_o    (pc_load),
      .pc_o         (pc_out),
      .psw_load_o   (psw_load),
      .psw_o        (psw_out)
   );

endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  src_req = '0, src_en = '0, clr_mask = '0;
   logic        nmi_req = 0, clr_cmd = 0, ei_cmd = 0, di_cmd = 0;
   logic        instr_done = 0, reti_cmd = 0;
   logic [15:0] pc_in = '0;
   logic [7:0]  psw_in = '0;
   logic        busy, irq_en, mem_we, mem_re, pc_load, psw_load;
   logic [7:0]  sp_out, mem_wdata, mem_rdata, psw_out;
   logic [15:0] mem_addr, pc_out;

   logic [7:0]  stk [0:255];
   int          checks = 0, errors = 0, cyc = 0;
   bit          done = 0;

   always #2 clk = ~clk;

   function automatic logic [7:0] vb(input logic [15:0] a);
      return a[7:0] * 8'd13 + 8'h21;
   endfunction

   assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : vb(mem_addr);

   always @(posedge clk)
      if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;

   irq_entry_seq dut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en), .nmi_req(nmi_req),
      .clr_cmd(clr_cmd), .clr_mask(clr_mask), .ei_cmd(ei_cmd), .di_cmd(di_cmd),
      .instr_done(instr_done), .reti_cmd(reti_cmd), .pc_in(pc_in), .psw_in(psw_in),
      .busy(busy), .irq_en(irq_en), .sp_out(sp_out), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
      .pc_load(pc_load), .pc_out(pc_out), .psw_load(psw_load), .psw_out(psw_out)
   );

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(); @(negedge clk); endtask

   task automatic pulse_req(input logic [3:0] m, input logic n);
      src_req = m; nmi_req = n; tick(); src_req = '0; nmi_req = 0;
   endtask

   task automatic pulse_clr(input logic [3:0] m);
      clr_cmd = 1; clr_mask = m; tick(); clr_cmd = 0; clr_mask = '0;
   endtask

   task automatic pulse_ei(input bit en);
      if (en) ei_cmd = 1; else di_cmd = 1;
      tick(); ei_cmd = 0; di_cmd = 0;
   endtask

   // src index 0..3 maskable, 4 non-maskable
   task automatic do_entry(input int src, input logic [15:0] pc, input logic [7:0] psw,
                           output logic [7:0] pushed);
      logic [7:0]  sp_b, ew;
      logic [15:0] v, ea, pcv;
      int nb = 0, nw = 0, nr = 0, lc = -1;
      bit wok = 1, rok = 1;
      v = 16'hFFE0 + 16'(2 * src);
      pushed = psw; pushed[2] = irq_en;
      sp_b = sp_out;
      pc_in = pc; psw_in = psw; instr_done = 1; tick(); instr_done = 0;
      pcv = '0;
      for (int c = 0; c < 12; c++) begin
         if (busy) nb++;
         if (mem_we) begin
            ea = {8'h01, sp_b - 8'(nw)};
            ew = (nw == 0) ? pc[15:8] : (nw == 1) ? pc[7:0] : pushed;
            if (mem_addr != ea || mem_wdata != ew || nw > 2) wok = 0;
            nw++;
         end
         if (mem_re) begin
            if (mem_addr != v + 16'(nr)) rok = 0;
            nr++;
         end
         if (pc_load) begin lc = c; pcv = pc_out; end
         tick();
      end
      chk(nb == 8, "R3 entry busy cycles", nb, 8);
      chk(lc == 7, "R3 pc_load cycle", lc, 7);
      chk(wok && nw == 3, "R7 push addr/data/order", nw, 3);
      chk(rok && nr == 2, "R8 vector read addresses", nr, 2);
      chk(pcv == {vb(v + 16'd1), vb(v)}, "R8 entry address", pcv, {vb(v + 16'd1), vb(v)});
      chk(sp_out == sp_b - 8'd3, "R7 sp after entry", sp_out, sp_b - 8'd3);
      chk(irq_en == 0, "R4 master flag cleared", irq_en, 0);
   endtask

   task automatic do_return(input logic [15:0] pc, input logic [7:0] psw);
      logic [7:0]  sp_b, sv;
      logic [15:0] pcv;
      int nb = 0, nr = 0, lc = -1;
      bit rok = 1;
      sp_b = sp_out; pcv = '0; sv = '0;
      reti_cmd = 1; tick(); reti_cmd = 0;
      for (int c = 0; c < 8; c++) begin
         if (busy) nb++;
         if (mem_re) begin
            if (mem_addr != {8'h01, sp_b + 8'(nr + 1)}) rok = 0;
            nr++;
         end
         if (pc_load && psw_load) begin lc = c; pcv = pc_out; sv = psw_out; end
         tick();
      end
      chk(nb == 4 && lc == 3, "R10 return length", nb, 4);
      chk(rok && nr == 3, "R10 pop addresses", nr, 3);
      chk(pcv == pc, "R10 restored pc", pcv, pc);
      chk(sv == psw, "R10 restored psw / R11 saved psw", sv, psw);
      chk(sp_out == sp_b + 8'd3, "R10 sp after return", sp_out, sp_b + 8'd3);
      chk(irq_en == psw[2], "R10 master flag restored", irq_en, psw[2]);
   endtask

   task automatic do_none(input string req);
      int nb = 0;
      instr_done = 1; tick(); instr_done = 0;
      for (int c = 0; c < 10; c++) begin
         if (busy || mem_we || mem_re) nb++;
         tick();
      end
      chk(nb == 0, req, nb, 0);
   endtask

   initial begin
      logic [7:0] pa, pb;
      int w;
      repeat (4) tick();
      chk(!busy && !pc_load && !mem_we && !mem_re, "R3 reset outputs idle", busy, 0);
      chk(irq_en == 0, "R5 reset master flag", irq_en, 0);
      chk(sp_out == 8'hFF, "R7 reset sp", sp_out, 8'hFF);
      rst_n = 1; tick();
      chk(!busy, "R3 idle after reset", busy, 0);

      // R5: master flag gates maskable requests
      src_en = 4'hF;
      pulse_req(4'b0010, 0);
      do_none("R5 blocked while master flag 0");
      pulse_ei(1);
      // R2: nothing without a completed instruction
      w = 0;
      for (int c = 0; c < 6; c++) begin if (busy) w++; tick(); end
      chk(w == 0, "R2 no acceptance without instr_done", w, 0);
      // R1: latch held across the blocked attempt
      do_entry(1, 16'h1234, 8'h81, pa);
      do_return(16'h1234, pa);
      do_none("R4 accepted latch cleared");

      // R1: clear command, selective
      pulse_req(4'b0100, 0);
      pulse_clr(4'b0100);
      do_none("R1 cleared latch not taken");
      pulse_req(4'b0101, 0);
      pulse_clr(4'b0100);
      do_entry(0, 16'hA55A, 8'h10, pa);
      do_return(16'hA55A, pa);
      do_none("R1 clear mask only dropped masked source");

      // R6 R5 R8: sweep pending x enable
      for (int p = 1; p < 16; p++) begin
         for (int e = 0; e < 16; e++) begin
            logic [3:0] m;
            m = 4'(p) & 4'(e);
            src_en = 4'(e);
            pulse_req(4'(p), 0);
            if (m == 0) begin
               do_none("R5 disabled sources ignored");
            end else begin
               w = 0;
               for (int k = 3; k >= 0; k--) if (m[k]) w = k;
               do_entry(w, 16'(p * 256 + e * 16 + 7), 8'(p * 16 + e), pa);
               do_return(16'(p * 256 + e * 16 + 7), pa);
            end
            pulse_clr(4'hF);
         end
      end

      // R9 R6: non-maskable wins and locks out everything
      src_en = 4'hF;
      pulse_req(4'b0001, 1);
      do_entry(4, 16'hBEEF, 8'h00, pa);
      pulse_ei(1);
      chk(irq_en == 1, "R5 ei sets master flag", irq_en, 1);
      do_none("R9 lockout after non-maskable entry");
      do_return(16'hBEEF, pa);
      do_entry(0, 16'h2000, 8'h00, pb);
      do_return(16'h2000, pb);

      // R9 R11: non-maskable taken with master flag 0
      pulse_ei(0);
      pulse_req(4'b0000, 1);
      do_entry(4, 16'h3456, 8'hFF, pa);
      chk(pa[2] == 0, "R11 saved enable bit", pa[2], 0);
      do_return(16'h3456, pa);

      // nesting
      pulse_ei(1);
      pulse_req(4'b0100, 0);
      do_entry(2, 16'h4000, 8'h33, pa);
      pulse_req(4'b0001, 0);
      do_none("R5 nested request blocked until ei");
      pulse_ei(1);
      do_entry(0, 16'h4100, 8'h40, pb);
      chk(sp_out == 8'hF9, "R7 nested sp", sp_out, 8'hF9);
      do_return(16'h4100, pb);
      do_return(16'h4000, pa);
      chk(sp_out == 8'hFF, "R10 sp back at top", sp_out, 8'hFF);

      summary();
   end

endmodule